// File: doc/BRIEF.md
# Parallel Channel Select Loader

This block turns a slow, asynchronous parallel selection interface into a clean frequency load. A 7-bit channel code and an active-low load strobe arrive from switches or another board. The strobe idles high. Both pass through two-flop synchronizers. A falling edge on the synchronized strobe captures the channel code. The strobe must then stay low for a minimum number of clock cycles, derived from the clock rate and a width in nanoseconds. Once it has, the block either rejects the code or reads that channel's frequency word from an external channel memory and makes it the active frequency.

After every qualified strobe, a hold-off window (derived from a spacing in microseconds) starts. Falling edges that arrive inside this window are dropped. Codes 120 to 127 have no channel behind them. They raise a one-cycle error pulse and leave the active frequency as it was. The memory read is a fixed-latency request: data must be valid on `mem_rdata` exactly one cycle after `mem_rd_en`. No pin has back-pressure, and the block never stalls. The active frequency is a held register that downstream synthesis logic can use directly, and `load_done` marks each change to it.

Top module: `chan_sel_loader`

## Requirements
- R1: While `rst_n` is low, and after it is released, `freq_out` equals the parameter `RESET_FREQ`. `load_done`, `sel_err` and `mem_rd_en` are low until the first qualified strobe.
- R2: The channel code is the value of `sel_in` captured, after synchronization, at the falling edge of `set_n`. Changes to `sel_in` while `set_n` stays low do not alter the channel that is loaded.
- R3: A strobe qualifies only if the synchronized `set_n` stays low for LOW_CYC = CLK_MHZ*MIN_LOW_NS/1000 consecutive cycles. A shorter low pulse causes no memory read, no `load_done`, no `sel_err`, and no change to `freq_out`.
- R4: A falling edge of `set_n` that arrives within REP_CYC = CLK_MHZ*REPEAT_US cycles of the previous qualified strobe is ignored entirely. This holds whether the previous strobe loaded a channel or was rejected.
- R5: For a qualified code below 120, `mem_rd_en` is high for one cycle with `mem_addr` equal to the code. Two cycles later, `freq_out` takes the value `mem_rdata` carried in the cycle after the read, and `load_done` pulses high for that one cycle.
- R6: For a qualified code from 120 to 127, `sel_err` pulses high for one cycle. No memory read is issued, and `freq_out` is unchanged.
- R7: Holding `set_n` low far beyond the minimum width yields exactly one load. `freq_out` holds its value between loads.
- R8: `load_done` rises no later than LOW_CYC+8 clock cycles after `set_n` falls at the pin. This keeps the load well inside the required settling budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_n | input | 1 | Asynchronous load strobe, active low, idles high |
| sel_in | input | 7 | Asynchronous channel code |
| mem_rd_en | output | 1 | One-cycle read request to channel memory |
| mem_addr | output | 7 | Channel address for the read |
| mem_rdata | input | FREQ_W | Frequency word, valid one cycle after `mem_rd_en` |
| freq_out | output | FREQ_W | Active frequency word |
| load_done | output | 1 | One-cycle pulse when `freq_out` is updated |
| sel_err | output | 1 | One-cycle pulse for an out-of-range code |

## Verification
The bench sends runt pulses shorter than the width limit. A design that skips the width filter would load on switch bounce. It also sends a second strobe inside the hold-off window. If the window is mis-timed, an extra or missing load results. The bench moves `sel_in` after the falling edge. A design that samples late would load the wrong channel. Codes 120 to 127 check that no read is issued and the frequency is not corrupted. A single very long strobe checks that it cannot load twice. Random codes and pulse lengths cover the remaining space against a channel-to-frequency function held in the bench.

// File: rtl/chan_sel_pkg.sv
package chan_sel_pkg;
  localparam int SEL_W  = 7;
  localparam int NUM_CH = 120;

  typedef enum logic {
    QS_IDLE,
    QS_MEAS
  } qual_state_t;
endpackage

// File: rtl/csl_sync2.sv
module csl_sync2 #(
  parameter int W = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= INIT;
      d_sync <= INIT;
    end else begin
      meta_q <= d_async;
      d_sync <= meta_q;
    end
  end
endmodule

// File: rtl/csl_strobe_qual.sv
module csl_strobe_qual
  import chan_sel_pkg::*;
#(
  parameter int LOW_CYC = 56,
  parameter int REP_CYC = 40000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_s,
  input  logic [SEL_W-1:0] sel_s,
  output logic             fire,
  output logic [SEL_W-1:0] code
);
  localparam int CNT_W      = $clog2(LOW_CYC + 1);
  localparam int GRD_W      = $clog2(REP_CYC + 1);
  localparam int GUARD_INIT = (REP_CYC > LOW_CYC) ? (REP_CYC - LOW_CYC) : 1;

  qual_state_t      state;
  logic             set_d;
  logic [CNT_W-1:0] cnt;
  logic [GRD_W-1:0] guard;
  logic             fall;

  assign fall = set_d & ~set_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= QS_IDLE;
      set_d <= 1'b1;
      cnt   <= '0;
      guard <= '0;
      fire  <= 1'b0;
      code  <= '0;
    end else begin
      set_d <= set_s;
      fire  <= 1'b0;
      if (guard != '0) guard <= guard - 1'b1;
      case (state)
        QS_IDLE: begin
          if (fall && guard == '0) begin
            state <= QS_MEAS;
            cnt   <= CNT_W'(1);
            code  <= sel_s;
          end
        end
        QS_MEAS: begin
          if (set_s) begin
            state <= QS_IDLE;
          end else if (cnt >= CNT_W'(LOW_CYC - 1)) begin
            fire  <= 1'b1;
            state <= QS_IDLE;
            guard <= GRD_W'(GUARD_INIT);
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= QS_IDLE;
      endcase
    end
  end

  assert_fire_needs_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> ($past(state) == QS_MEAS && !$past(set_s)));

  assert_holdoff_drops_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == QS_IDLE && fall && guard != '0) |=> state == QS_IDLE);

  assert_code_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == QS_MEAS) |=> $stable(code));
endmodule

// File: rtl/csl_load_stage.sv
module csl_load_stage
  import chan_sel_pkg::*;
#(
  parameter int          FREQ_W     = 32,
  parameter logic [31:0] RESET_FREQ = 32'd10_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [SEL_W-1:0]  code,
  output logic              mem_rd_en,
  output logic [SEL_W-1:0]  mem_addr,
  input  logic [FREQ_W-1:0] mem_rdata,
  output logic [FREQ_W-1:0] freq,
  output logic              done,
  output logic              err
);
  logic rd_wait;
  logic in_range;

  assign in_range = (code < SEL_W'(NUM_CH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rd_en <= 1'b0;
      mem_addr  <= '0;
      rd_wait   <= 1'b0;
      freq      <= FREQ_W'(RESET_FREQ);
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      mem_rd_en <= fire & in_range;
      err       <= fire & ~in_range;
      if (fire && in_range) mem_addr <= code;
      rd_wait <= mem_rd_en;
      done    <= rd_wait;
      if (rd_wait) freq <= mem_rdata;
    end
  end

  assert_no_read_oor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (mem_addr < SEL_W'(NUM_CH)));

  assert_err_keeps_freq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $stable(freq));

  assert_done_follows_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_rd_en, 2));

  assert_single_outcome_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
endmodule

// File: rtl/chan_sel_loader.sv
module chan_sel_loader
  import chan_sel_pkg::*;
#(
  parameter int          CLK_MHZ    = 100,
  parameter int          MIN_LOW_NS = 560,
  parameter int          REPEAT_US  = 400,
  parameter int          FREQ_W     = 32,
  parameter logic [31:0] RESET_FREQ = 32'd10_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_n,
  input  logic [6:0]        sel_in,
  output logic              mem_rd_en,
  output logic [6:0]        mem_addr,
  input  logic [FREQ_W-1:0] mem_rdata,
  output logic [FREQ_W-1:0] freq_out,
  output logic              load_done,
  output logic              sel_err
);
  localparam int LOW_RAW = (CLK_MHZ * MIN_LOW_NS) / 1000;
  localparam int LOW_CYC = (LOW_RAW < 2) ? 2 : LOW_RAW;
  localparam int REP_CYC = CLK_MHZ * REPEAT_US;

  logic             set_s;
  logic [SEL_W-1:0] sel_s;
  logic             fire;
  logic [SEL_W-1:0] code;

  csl_sync2 #(.W(1), .INIT(1'b1)) u_sync_set (
    .clk(clk), .rst_n(rst_n), .d_async(set_n), .d_sync(set_s)
  );

  csl_sync2 #(.W(SEL_W), .INIT('0)) u_sync_sel (
    .clk(clk), .rst_n(rst_n), .d_async(sel_in), .d_sync(sel_s)
  );

  csl_strobe_qual #(.LOW_CYC(LOW_CYC), .REP_CYC(REP_CYC)) u_qual (
    .clk(clk), .rst_n(rst_n), .set_s(set_s), .sel_s(sel_s),
    .fire(fire), .code(code)
  );

  csl_load_stage #(.FREQ_W(FREQ_W), .RESET_FREQ(RESET_FREQ)) u_load (
    .clk(clk), .rst_n(rst_n), .fire(fire), .code(code),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .freq(freq_out), .done(load_done), .err(sel_err)
  );

  assert_quiet_without_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (set_s && $past(set_s) && $past(set_s, 2)) |-> !mem_rd_en || $past(fire));
endmodule

// File: tb/chan_sel_loader_bench.sv
`timescale 1ns/1ps
module chan_sel_loader_bench;
  localparam int CLK_MHZ    = 100;
  localparam int MIN_LOW_NS = 560;
  localparam int REPEAT_US  = 20;
  localparam int FREQ_W     = 32;
  localparam int LOW_CYC    = CLK_MHZ * MIN_LOW_NS / 1000;
  localparam int REP_CYC    = CLK_MHZ * REPEAT_US;
  localparam logic [31:0] RST_F = 32'd10_000_000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              set_n = 1'b1;
  logic [6:0]        sel_in = '0;
  logic              mem_rd_en;
  logic [6:0]        mem_addr;
  logic [FREQ_W-1:0] mem_rdata = '0;
  logic [FREQ_W-1:0] freq_out;
  logic              load_done;
  logic              sel_err;

  always #5 clk = ~clk;

  chan_sel_loader #(
    .CLK_MHZ(CLK_MHZ), .MIN_LOW_NS(MIN_LOW_NS), .REPEAT_US(REPEAT_US),
    .FREQ_W(FREQ_W), .RESET_FREQ(RST_F)
  ) u_chan_sel_loader (
    .clk(clk), .rst_n(rst_n), .set_n(set_n), .sel_in(sel_in),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .freq_out(freq_out), .load_done(load_done), .sel_err(sel_err)
  );

  function automatic logic [FREQ_W-1:0] chan_freq(input logic [6:0] a);
    return FREQ_W'(32'd1_000_000 + 32'(a) * 32'd1_048_573);
  endfunction

  always_ff @(posedge clk) if (mem_rd_en) mem_rdata <= chan_freq(mem_addr);

  int cyc = 0, n_done = 0, n_err = 0, n_rd = 0, done_cyc = 0;
  logic [6:0] last_addr = '0;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (load_done) begin n_done <= n_done + 1; done_cyc <= cyc; end
    if (sel_err)   n_err <= n_err + 1;
    if (mem_rd_en) begin n_rd <= n_rd + 1; last_addr <= mem_addr; end
  end

  int checks = 0, fails = 0;
  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  logic [FREQ_W-1:0] exp_f = RST_F;
  int low_cyc_at = 0;

  task automatic strobe(input logic [6:0] c, input int low, input int move_at);
    @(negedge clk); sel_in = c;
    repeat (4) @(negedge clk);
    set_n = 1'b0; low_cyc_at = cyc;
    for (int i = 0; i < low; i++) begin
      @(negedge clk);
      if (i == move_at) sel_in = ~c;
    end
    set_n = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  // expected outcome for a strobe that is not blocked by hold-off
  task automatic run_case(input string req, input logic [6:0] c, input int low, input int move_at);
    int d0, e0, r0;
    d0 = n_done; e0 = n_err; r0 = n_rd;
    strobe(c, low, move_at);
    if (low < LOW_CYC) begin
      chk({req, "/R3 runt done"}, n_done - d0, 0);
      chk({req, "/R3 runt rd"}, n_rd - r0, 0);
      chk({req, "/R3 runt err"}, n_err - e0, 0);
    end else if (c >= 7'd120) begin
      chk({req, "/R6 err"}, n_err - e0, 1);
      chk({req, "/R6 rd"}, n_rd - r0, 0);
    end else begin
      exp_f = chan_freq(c);
      chk({req, "/R5 done"}, n_done - d0, 1);
      chk({req, "/R5 addr"}, last_addr, c);
      chk({req, "/R8 latency"}, (done_cyc - low_cyc_at) <= LOW_CYC + 8, 1);
    end
    chk({req, "/R7 freq"}, freq_out, exp_f);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_0042);
    repeat (5) @(negedge clk);
    chk("R1 freq", freq_out, RST_F);
    chk("R1 done", load_done, 0);
    chk("R1 err", sel_err, 0);
    chk("R1 rd", mem_rd_en, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R1 after release", freq_out, RST_F);

    run_case("R3 runt", 7'd5, LOW_CYC / 2, -1);
    run_case("R5 chan0", 7'd0, LOW_CYC + 20, -1);
    repeat (REP_CYC) @(negedge clk);
    run_case("R2 sel moves", 7'd37, LOW_CYC + 20, 10);
    repeat (REP_CYC) @(negedge clk);
    // R4: second strobe inside hold-off is dropped
    begin
      int d0, r0;
      d0 = n_done; r0 = n_rd;
      strobe(7'd90, LOW_CYC + 30, -1);
      chk("R4 first", n_done - d0, 1);
      exp_f = chan_freq(7'd90);
      repeat (REP_CYC / 3) @(negedge clk);
      strobe(7'd11, LOW_CYC + 30, -1);
      chk("R4 holdoff done", n_done - d0, 1);
      chk("R4 holdoff rd", n_rd - r0, 1);
      chk("R4 holdoff freq", freq_out, exp_f);
    end
    repeat (REP_CYC) @(negedge clk);
    run_case("R5 chan119", 7'd119, LOW_CYC + 20, -1);
    repeat (REP_CYC) @(negedge clk);
    run_case("R6 code120", 7'd120, LOW_CYC + 20, -1);
    repeat (REP_CYC) @(negedge clk);
    run_case("R6 code127", 7'd127, LOW_CYC + 20, -1);
    repeat (REP_CYC) @(negedge clk);
    run_case("R7 long hold", 7'd64, LOW_CYC * 20, -1);
    repeat (REP_CYC) @(negedge clk);

    for (int k = 0; k < 30; k++) begin
      logic [6:0] c;
      int low;
      c = 7'($urandom % 128);
      low = ($urandom % 10 == 0) ? (5 + int'($urandom % 40)) : (LOW_CYC + 15 + int'($urandom % 200));
      run_case("RND", c, low, -1);
      repeat (REP_CYC) @(negedge clk);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1_900_000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule